// File: doc/BRIEF.md
# PLL Frequency Lock Detector

This block decides how closely a PLL's divided feedback clock tracks its reference oscillator clock and reports the answer on two status bits. One bit is a coarse lock and the other is a fine lock. Both incoming clocks are asynchronous to the block. Each one is brought into a fast sampling clock domain, and there its rising edges are turned into single-cycle pulses.

Each of the two pulse streams has its own period counter. A measurement window closes when the reference counter reaches `W` periods. At that point the two counts are compared. The size of their difference sets the lock grade, and that grade is held until the next window closes.

The block is enabled by a lock-detect enable and by an active-high power-down input. Whenever it is disabled, it clears its counters and both status bits.

Top module: `pll_lock_detector`

## Requirements
- R1: While `rst_n` is low, or while `detect_en` is low or `pwr_down` is high, both lock outputs are 0 from the next clock edge on, and both period counters are cleared.
- R2: Each input clock passes through a two-flop synchronizer followed by a rising-edge detector. A rising input edge first sampled at clock edge k produces a counted pulse at edge k+2. Only rising edges are counted, so the duty cycle of the feedback clock has no effect on the result.
- R3: A window closes in the cycle in which the reference count equals `W` (default 64). The counts held in that cycle are the ones compared. Both counters then reload with that cycle's edge pulse (0 or 1), so no edge is lost across the boundary.
- R4: At a window close, `coarse_lock` becomes 1 if the absolute difference between the feedback count and the reference count is at most `C` (default 4), and 0 otherwise.
- R5: At a window close, `fine_lock` becomes 1 if the absolute difference is at most `F` (default 1, with F ≤ C). `fine_lock` is never 1 while `coarse_lock` is 0.
- R6: The lock outputs are registered. They change only on the clock edge that ends a window-close cycle, and they hold their value in every other enabled cycle.
- R7: The feedback counter saturates at 2^(clog2(W)+1)−1, which is 127 for the default. A window that closes with the counter saturated clears both lock outputs.
- R8: After the block is re-enabled, both outputs stay 0 until a full window of `W` reference periods has been counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; must run more than twice as fast as either input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fb_clk_i | input | 1 | Divided feedback clock from the PLL, asynchronous |
| ref_clk_i | input | 1 | Reference oscillator clock, asynchronous |
| detect_en | input | 1 | Lock-detect enable, active high |
| pwr_down | input | 1 | PLL power-down, active high; holds the detector cleared |
| coarse_lock | output | 1 | Frequency difference per window within `C` periods |
| fine_lock | output | 1 | Frequency difference per window within `F` periods |

## Verification
The hardest outcome to reach from the ports is the narrow band in which the coarse bit is set and the fine bit is clear: the counts must differ by 2 to 4 in every window. The stimulus reaches it with a feedback clock at the reference period whose every sixteenth period is stretched to double length. That pattern fixes the per-window deficit at three or four periods.

Saturation is reached with a feedback clock about three times faster than the reference. Random period jitter of ±1 cycle spreads the other windows across all three grades. Every one of these runs is compared cycle by cycle against a bench model of the windowing rules.

// File: rtl/lkd_pkg.sv
// Package: shared types and constants for the PLL frequency lock detector.
// Assumes: two monitored clocks, reference at index 0 and feedback at index 1.
package lkd_pkg;

    localparam int LKD_NUM_CLKS = 2;
    localparam int LKD_IDX_REF  = 0;
    localparam int LKD_IDX_FB   = 1;

    // Two-level lock grade produced at each window close.
    typedef struct packed {
        logic coarse;
        logic fine;
    } lock_grade_t;

endpackage

// File: rtl/lkd_edge_sync.sv
// Module: lkd_edge_sync
// Brings one asynchronous clock into the sampling domain through STAGES
// flops, then emits a one-cycle pulse for each rising edge it sees.
// Assumes: the sampling clock runs more than twice as fast as the input, so
// every high phase and every low phase is sampled at least once.
module lkd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    // pipe[STAGES-1] is the synchronized level; pipe[STAGES] is its previous value
    logic [STAGES:0] pipe;

    // Shift the input through the synchronizer and one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-1:0], async_i};
        end
    end

    // Rising edge: synchronized level is high now and was low one cycle earlier
    assign rise_o = pipe[STAGES-1] & ~pipe[STAGES];

    // R2: an edge pulse never lasts longer than one cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/lkd_window_counter.sv
// Module: lkd_window_counter
// Holds the reference and feedback period counters. A window closes when the
// reference count equals W. The feedback counter saturates at its maximum
// value instead of wrapping.
// Assumes: ref_rise and fb_rise are single-cycle pulses in the clk domain.
module lkd_window_counter #(
    parameter int W  = 64,
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          ref_rise,
    input  logic          fb_rise,
    output logic [CW-1:0] ref_cnt,
    output logic [CW-1:0] fb_cnt,
    output logic          win_end,
    output logic          fb_sat
);

    localparam logic [CW-1:0] WIN_LAST = CW'(W);
    localparam logic [CW-1:0] SAT_VAL  = {CW{1'b1}};

    assign win_end = active && (ref_cnt == WIN_LAST);
    assign fb_sat  = (fb_cnt == SAT_VAL);

    // Reference counter: clear when idle, reload at a window close, else count edges
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            ref_cnt <= '0;
        end else if (win_end) begin
            ref_cnt <= {{(CW-1){1'b0}}, ref_rise};
        end else begin
            ref_cnt <= ref_cnt + {{(CW-1){1'b0}}, ref_rise};
        end
    end

    // Feedback counter: same windowing, but it holds once it reaches its maximum
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            fb_cnt <= '0;
        end else if (win_end) begin
            fb_cnt <= {{(CW-1){1'b0}}, fb_rise};
        end else if (!fb_sat) begin
            fb_cnt <= fb_cnt + {{(CW-1){1'b0}}, fb_rise};
        end
    end

    // R3: the reference count never runs past the window length
    a_r3_ref_within_window: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cnt <= WIN_LAST);

    // R1: a disabled detector leaves both counters at zero
    a_r1_counters_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (ref_cnt == '0) && (fb_cnt == '0));

    // R7: a saturated feedback count stays saturated until the window closes
    a_r7_sat_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        active && fb_sat && !win_end |=> fb_sat);

endmodule

// File: rtl/lkd_lock_grader.sv
// Module: lkd_lock_grader
// Compares the two period counts at each window close and registers a
// coarse/fine lock grade. The grade is held between closes.
// Assumes: F <= C, and C < 2**CW.
module lkd_lock_grader
    import lkd_pkg::*;
#(
    parameter int CW = 7,
    parameter int C  = 4,
    parameter int F  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          win_end,
    input  logic          fb_sat,
    input  logic [CW-1:0] ref_cnt,
    input  logic [CW-1:0] fb_cnt,
    output logic          coarse_o,
    output logic          fine_o
);

    localparam logic [CW-1:0] COARSE_TOL = CW'(C);
    localparam logic [CW-1:0] FINE_TOL   = CW'(F);

    logic [CW-1:0] gap;
    lock_grade_t   grade_q;
    lock_grade_t   grade_d;

    // Absolute difference between the two period counts
    assign gap = (fb_cnt >= ref_cnt) ? (fb_cnt - ref_cnt) : (ref_cnt - fb_cnt);

    // Grade the current counts; a saturated feedback count is out of lock
    always_comb begin
        grade_d.coarse = !fb_sat && (gap <= COARSE_TOL);
        grade_d.fine   = !fb_sat && (gap <= FINE_TOL);
    end

    // Register the grade at window closes and clear it whenever the detector is idle
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            grade_q <= '0;
        end else if (win_end) begin
            grade_q <= grade_d;
        end
    end

    assign coarse_o = grade_q.coarse;
    assign fine_o   = grade_q.fine;

    // R5: fine lock only ever appears together with coarse lock
    a_r5_fine_needs_coarse: assert property (@(posedge clk) disable iff (!rst_n)
        fine_o |-> coarse_o);

    // R6: outside a window close the grade holds
    a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        active && !win_end |=> $stable(coarse_o) && $stable(fine_o));

    // R1: a disabled detector reports no lock
    a_r1_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !coarse_o && !fine_o);

    // R7: a window that closes saturated reports no lock
    a_r7_sat_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        win_end && fb_sat |=> !coarse_o && !fine_o);

endmodule

// File: rtl/pll_lock_detector.sv
// Module: pll_lock_detector (top)
// Grades PLL frequency lock by counting whole feedback-clock and
// reference-clock periods over a window of W reference periods.
// Assumes: clk is more than twice as fast as either input clock; rst_n is
// synchronous to clk.
module pll_lock_detector
    import lkd_pkg::*;
#(
    parameter int W           = 64,
    parameter int C           = 4,
    parameter int F           = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fb_clk_i,
    input  logic ref_clk_i,
    input  logic detect_en,
    input  logic pwr_down,
    output logic coarse_lock,
    output logic fine_lock
);

    localparam int CW = $clog2(W) + 1;

    logic [LKD_NUM_CLKS-1:0] raw_clk;
    logic [LKD_NUM_CLKS-1:0] clk_rise;
    logic [CW-1:0]           ref_cnt;
    logic [CW-1:0]           fb_cnt;
    logic                    win_end;
    logic                    fb_sat;
    logic                    active;

    assign raw_clk[LKD_IDX_REF] = ref_clk_i;
    assign raw_clk[LKD_IDX_FB]  = fb_clk_i;

    // The detector runs only while enabled and not powered down
    assign active = detect_en && !pwr_down;

    // One synchronizer and edge detector for each monitored clock
    for (genvar g = 0; g < LKD_NUM_CLKS; g++) begin : g_sync
        lkd_edge_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (raw_clk[g]),
            .rise_o  (clk_rise[g])
        );
    end

    lkd_window_counter #(
        .W  (W),
        .CW (CW)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .ref_rise (clk_rise[LKD_IDX_REF]),
        .fb_rise  (clk_rise[LKD_IDX_FB]),
        .ref_cnt  (ref_cnt),
        .fb_cnt   (fb_cnt),
        .win_end  (win_end),
        .fb_sat   (fb_sat)
    );

    lkd_lock_grader #(
        .CW (CW),
        .C  (C),
        .F  (F)
    ) u_grade (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .win_end  (win_end),
        .fb_sat   (fb_sat),
        .ref_cnt  (ref_cnt),
        .fb_cnt   (fb_cnt),
        .coarse_o (coarse_lock),
        .fine_o   (fine_lock)
    );

endmodule

// File: tb/tb_pll_lock_detector.sv
// Bench for pll_lock_detector. Both input clocks are generated from clk
// cycle counts and driven on the falling edge. A bench model of the windowing
// rules predicts the lock outputs each cycle. Directed phases reach the
// fine-lock, coarse-only, saturation and re-enable cases, and a random-jitter
// phase mixes outcomes.
module tb_pll_lock_detector;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 64;
    localparam int C          = 4;
    localparam int F          = 1;
    localparam int CNTW       = $clog2(W) + 1;
    localparam int SATV       = (1 << CNTW) - 1;
    localparam int REF_PER    = 8;
    localparam int WIN_CYC    = W * REF_PER + 8;
    localparam int WDOG       = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fb_clk = 1'b0;
    logic ref_clk = 1'b0;
    logic en = 1'b0;
    logic pd = 1'b0;
    logic coarse_lock;
    logic fine_lock;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit model_cmp = 1'b0;

    // generator settings
    int fb_hi = 2;
    int fb_lo = 6;
    bit jitter = 1'b0;
    bit stretch = 1'b0;
    int ref_ph = 0;
    int fb_ph = 0;
    int fb_idx = 0;
    int cur_lo = 6;

    // bench model state
    logic [2:0] m_r = '0;
    logic [2:0] m_f = '0;
    int m_ref = 0;
    int m_fb = 0;
    logic m_c = 1'b0;
    logic m_fi = 1'b0;
    int n_fine = 0;
    int n_conly = 0;
    int n_none = 0;
    int n_sat = 0;

    pll_lock_detector #(.W(W), .C(C), .F(F)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .fb_clk_i    (fb_clk),
        .ref_clk_i   (ref_clk),
        .detect_en   (en),
        .pwr_down    (pd),
        .coarse_lock (coarse_lock),
        .fine_lock   (fine_lock)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int absdiff(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s coarse/fine actual=%b expected=%b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Generate both input clocks; the feedback clock has a configurable duty, jitter and stretch
    always @(negedge clk) begin
        ref_ph = (ref_ph + 1) % REF_PER;
        ref_clk <= (ref_ph < REF_PER / 2);
        fb_ph = fb_ph + 1;
        if (fb_ph >= fb_hi + cur_lo) begin
            fb_ph = 0;
            fb_idx++;
            cur_lo = fb_lo;
            if (jitter) cur_lo = cur_lo + int'($urandom_range(2)) - 1;
            if (stretch && (fb_idx % 16 == 15)) cur_lo = cur_lo + REF_PER;
        end
        fb_clk <= (fb_ph < fb_hi);
    end

    // Bench model of R1-R7: sync delay, windowing, saturation and grading
    always @(posedge clk) begin
        logic rr;
        logic rf;
        logic act;
        logic wend;
        logic sat;
        int gap;
        cyc++;
        rr = m_r[1] & ~m_r[2];
        rf = m_f[1] & ~m_f[2];
        act = en & ~pd;
        wend = act && (m_ref == W);
        sat = (m_fb == SATV);
        if (!rst_n) begin
            m_r = '0; m_f = '0; m_ref = 0; m_fb = 0; m_c = 0; m_fi = 0;
        end else begin
            m_r = {m_r[1:0], ref_clk};
            m_f = {m_f[1:0], fb_clk};
            if (!act) begin
                m_ref = 0; m_fb = 0; m_c = 0; m_fi = 0;
            end else if (wend) begin
                gap = absdiff(m_fb, m_ref);
                m_c = !sat && (gap <= C);
                m_fi = !sat && (gap <= F);
                if (sat) n_sat++;
                if (m_fi) n_fine++;
                else if (m_c) n_conly++;
                else n_none++;
                m_ref = int'(rr);
                m_fb = int'(rf);
            end else begin
                m_ref = m_ref + int'(rr);
                if (!sat) m_fb = m_fb + int'(rf);
            end
        end
    end

    // R6: every cycle the outputs must match the model's registered grade
    always @(negedge clk) begin
        if (model_cmp) chk("R6", {coarse_lock, fine_lock}, {m_c, m_fi});
    end

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        if (cyc > WDOG) begin
            errors++;
            $display("FAIL watchdog actual=%0d cycles expected<=%0d", cyc, WDOG);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        wait_cycles(6);
        chk("R1 reset", {coarse_lock, fine_lock}, 2'b00);
        rst_n = 1'b1;
        en = 1'b1;
        wait_cycles(2);
        model_cmp = 1'b1;

        // R2: matched period, 25% duty feedback -> fine lock
        wait_cycles(3 * WIN_CYC);
        chk("R2 duty/R5 matched", {coarse_lock, fine_lock}, 2'b11);

        // R1: disable clears; R8: re-enable waits a full window
        en = 1'b0;
        wait_cycles(2);
        chk("R1 disable", {coarse_lock, fine_lock}, 2'b00);
        wait_cycles(40);
        en = 1'b1;
        for (int i = 0; i < W * REF_PER - 40; i++) begin
            @(negedge clk);
            chk("R8 no early lock", {coarse_lock, fine_lock}, 2'b00);
        end
        wait_cycles(2 * WIN_CYC);
        chk("R8 relock", {coarse_lock, fine_lock}, 2'b11);

        // R1: power-down clears
        pd = 1'b1;
        wait_cycles(2);
        chk("R1 power-down", {coarse_lock, fine_lock}, 2'b00);
        wait_cycles(30);
        pd = 1'b0;

        // R4: stretched periods give a deficit of 3-4 -> coarse only
        stretch = 1'b1;
        wait_cycles(3 * WIN_CYC);
        chk("R4 coarse only", {coarse_lock, fine_lock}, 2'b10);

        // R3: slower feedback (period 16) is far out of lock
        stretch = 1'b0;
        fb_hi = 8;
        fb_lo = 8;
        wait_cycles(3 * WIN_CYC);
        chk("R3 slow feedback", {coarse_lock, fine_lock}, 2'b00);

        // R7: fast feedback saturates the counter
        fb_hi = 1;
        fb_lo = 2;
        wait_cycles(3 * WIN_CYC);
        chk("R7 saturated", {coarse_lock, fine_lock}, 2'b00);

        // Random jitter around the matched period
        fb_hi = 2;
        fb_lo = 6;
        jitter = 1'b1;
        wait_cycles(40 * WIN_CYC);

        model_cmp = 1'b0;
        chk("R5 fine windows seen", {1'b0, n_fine > 0}, 2'b01);
        chk("R4 coarse-only windows seen", {1'b0, n_conly > 0}, 2'b01);
        chk("R7 saturated windows seen", {1'b0, n_sat > 0}, 2'b01);
        chk("R3 unlocked windows seen", {1'b0, n_none > 0}, 2'b01);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule